// File: doc/BRIEF.md
# In-Order Result Commitment Unit

This block sits between the dispatch stage and the architectural register file of a core whose execution units may finish work in any order. Every dispatched instruction claims one slot of a small circular buffer, and the slot index doubles as the number of the temporary result register that holds the instruction's value until it is committed. Execution units report completion by tag, carrying the result and an exception flag. Completions may arrive in any order.

Each clock, the unit looks at the oldest outstanding slot and the one after it. Finished, exception-free instructions are copied to the architectural register file through two write ports, oldest first, so architectural state only ever changes in program order. When the oldest slot finished with an exception, the unit reports that instruction's tag. In the same cycle it discards every younger instruction, whether finished or not, and empties the buffer. This makes the exception precise. Slots that leave the buffer, retired or discarded, are returned through a free mask so dispatch can reuse their temporary registers.

Top module: `retire_order_unit`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `wr0_en`, `wr1_en`, `exc_valid` and `free_mask` are all 0.
- R2: A tag is {epoch bit in the MSB, slot index in the low bits}. Accepted allocations take slot indices 0,1,2,... wrapping modulo DEPTH. `alloc_ready` is 0 while DEPTH instructions are outstanding and in a cycle that reports an exception. An allocation offered while `alloc_ready` is 0 is dropped.
- R3: A completion stores its result in the slot's temporary register. The value reaches a write port only when that instruction commits, and it carries the data of the completion.
- R4: `wr0_en` is 1 exactly when the oldest outstanding instruction has completed without an exception. It then carries that instruction's destination and result.
- R5: `wr1_en` is 1 exactly when port 0 commits in the same cycle and the second-oldest instruction has also completed without an exception. It then carries the second instruction's destination and result.
- R6: When the oldest instruction has completed with an exception, `exc_valid` is 1 and `exc_tag` is its tag. Neither write port commits in that cycle. No younger instruction ever commits. The next allocation gets slot 0 with the epoch bit inverted.
- R7: A completion whose epoch bit differs from the current epoch, or whose slot is not outstanding, changes nothing.
- R8: `free_mask` has one bit per slot. A bit is set in the cycle that slot's instruction commits, or, when an exception is reported, for every outstanding slot.
- R9: An instruction that completed with an exception but is not the oldest raises no report until all older instructions have committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch offers one instruction |
| alloc_dest | input | AREG_W | Architectural destination of that instruction |
| alloc_ready | output | 1 | Offer accepted this cycle |
| alloc_tag | output | IDX_W+1 | Tag given to the accepted instruction |
| cmp_valid | input | 1 | An execution unit reports a completion |
| cmp_tag | input | IDX_W+1 | Tag of the completed instruction |
| cmp_data | input | DATA_W | Result value |
| cmp_exc | input | 1 | Instruction raised an exception |
| wr0_en | output | 1 | Commit of the oldest instruction |
| wr0_addr | output | AREG_W | Destination for port 0 |
| wr0_data | output | DATA_W | Value for port 0 |
| wr1_en | output | 1 | Commit of the second-oldest instruction |
| wr1_addr | output | AREG_W | Destination for port 1 |
| wr1_data | output | DATA_W | Value for port 1 |
| exc_valid | output | 1 | Precise exception report and flush |
| exc_tag | output | IDX_W+1 | Tag of the excepting instruction |
| free_mask | output | DEPTH | Temporary registers released this cycle |

## Verification
Full buffers are completed in six fixed orders: in order, reverse, two strides, pair swap and half rotation. These separate single commits from paired commits, and show whether a finished instruction behind an unfinished one is held. An exception is then placed at every one of the eight positions with reverse completion order. This tells an early, out-of-order report apart from a correct one at the head, and shows whether any younger result leaks. Completions tagged with the previous epoch, sent both to empty slots and to slots reused after a flush, tell stale results apart from live ones. A long pseudo-random run mixes all of these with back-pressure at full occupancy.

// File: rtl/retire_pkg.sv
package retire_pkg;

  // Outcome of the commit decision for one cycle.
  typedef enum logic [1:0] {
    RET_NONE  = 2'd0,
    RET_ONE   = 2'd1,
    RET_TWO   = 2'd2,
    RET_FLUSH = 2'd3
  } ret_kind_e;

endpackage

// File: rtl/retire_ptrs.sv
module retire_ptrs #(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [1:0]       pop_n,
  input  logic             flush,
  output logic [IDX_W-1:0] head_q,
  output logic [IDX_W-1:0] tail_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             epoch_q,
  output logic             full
);

  logic [IDX_W-1:0] head_d, tail_d;
  logic [CNT_W-1:0] cnt_d;
  logic             epoch_d;

  function automatic logic [IDX_W-1:0] adv(input logic [IDX_W-1:0] p, input int unsigned n);
    int unsigned s;
    s = 32'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return s[IDX_W-1:0];
  endfunction

  assign full = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    cnt_d   = cnt_q;
    epoch_d = epoch_q;
    if (flush) begin
      head_d  = '0;
      tail_d  = '0;
      cnt_d   = '0;
      epoch_d = ~epoch_q;
    end else begin
      head_d = adv(head_q, 32'(pop_n));
      tail_d = adv(tail_q, 32'(push));
      cnt_d  = cnt_q + CNT_W'(push) - CNT_W'(pop_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      epoch_q <= 1'b0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      cnt_q   <= cnt_d;
      epoch_q <= epoch_d;
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH))
    else $error("occupancy above depth");

  a_r2_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push)
    else $error("allocation accepted while full");

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0) && (head_q == '0) && (tail_q == '0))
    else $error("flush did not empty the buffer");

endmodule

// File: rtl/retire_entries.sv
module retire_entries #(
  parameter  int DEPTH  = 8,
  parameter  int DATA_W = 32,
  parameter  int AREG_W = 5,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [AREG_W-1:0] alloc_dest,
  input  logic              cmp_en,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              cmp_exc,
  input  logic [DEPTH-1:0]  clr_mask,
  output logic [DEPTH-1:0]  valid_o,
  output logic [DEPTH-1:0]  done_o,
  output logic [DEPTH-1:0]  exc_o,
  output logic [AREG_W-1:0] dest_o [DEPTH],
  output logic [DATA_W-1:0] data_o [DEPTH]
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              v_q, v_d, d_q, d_d, e_q, e_d;
    logic              hit_a, hit_c;
    logic [AREG_W-1:0] dest_q;
    logic [DATA_W-1:0] data_q;

    assign hit_a = alloc_en && (alloc_idx == IDX_W'(g));
    assign hit_c = cmp_en   && (cmp_idx   == IDX_W'(g));

    always_comb begin
      v_d = v_q;
      d_d = d_q;
      e_d = e_q;
      if (clr_mask[g]) begin
        v_d = 1'b0;
        d_d = 1'b0;
        e_d = 1'b0;
      end
      if (hit_a) begin
        v_d = 1'b1;
        d_d = 1'b0;
        e_d = 1'b0;
      end
      if (hit_c) begin
        d_d = 1'b1;
        e_d = cmp_exc;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        e_q <= 1'b0;
      end else begin
        v_q <= v_d;
        d_q <= d_d;
        e_q <= e_d;
      end
    end

    // Temporary register payload: loaded under enable, no reset needed.
    always_ff @(posedge clk) begin
      if (hit_a) dest_q <= alloc_dest;
      if (hit_c) data_q <= cmp_data;
    end

    assign valid_o[g] = v_q;
    assign done_o[g]  = d_q;
    assign exc_o[g]   = e_q;
    assign dest_o[g]  = dest_q;
    assign data_o[g]  = data_q;

    a_r7_no_cmp_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
      hit_c |-> v_q)
      else $error("completion written into an idle slot");
  end

endmodule

// File: rtl/retire_select.sv
module retire_select #(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]         head,
  input  logic [DEPTH-1:0]         valid,
  input  logic [DEPTH-1:0]         done,
  input  logic [DEPTH-1:0]         exc,
  output retire_pkg::ret_kind_e    kind,
  output logic [IDX_W-1:0]         idx0,
  output logic [IDX_W-1:0]         idx1,
  output logic [DEPTH-1:0]         rel_mask
);
  import retire_pkg::*;

  logic ok0, ok1;

  assign idx0 = head;
  assign idx1 = (32'(head) == DEPTH - 1) ? '0 : head + 1'b1;
  assign ok0  = valid[idx0] && done[idx0];
  assign ok1  = valid[idx1] && done[idx1] && !exc[idx1];

  always_comb begin
    if (!ok0)           kind = RET_NONE;
    else if (exc[idx0]) kind = RET_FLUSH;
    else if (ok1)       kind = RET_TWO;
    else                kind = RET_ONE;
  end

  always_comb begin
    rel_mask = '0;
    if (kind == RET_FLUSH) begin
      rel_mask = valid;
    end else begin
      if (kind != RET_NONE) rel_mask[idx0] = 1'b1;
      if (kind == RET_TWO)  rel_mask[idx1] = 1'b1;
    end
  end

endmodule

// File: rtl/retire_order_unit.sv
module retire_order_unit #(
  parameter  int DEPTH  = 8,
  parameter  int DATA_W = 32,
  parameter  int AREG_W = 5,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int TAG_W  = IDX_W + 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [AREG_W-1:0] alloc_dest,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              cmp_exc,
  output logic              wr0_en,
  output logic [AREG_W-1:0] wr0_addr,
  output logic [DATA_W-1:0] wr0_data,
  output logic              wr1_en,
  output logic [AREG_W-1:0] wr1_addr,
  output logic [DATA_W-1:0] wr1_data,
  output logic              exc_valid,
  output logic [TAG_W-1:0]  exc_tag,
  output logic [DEPTH-1:0]  free_mask
);
  import retire_pkg::*;

  logic [IDX_W-1:0]  head, tail, idx0, idx1, cmp_idx;
  logic [CNT_W-1:0]  cnt;
  logic              epoch, full, flush, push, cmp_hit;
  logic [1:0]        pop_n;
  logic [DEPTH-1:0]  v_q, d_q, e_q, rel_mask;
  logic [AREG_W-1:0] dest_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  ret_kind_e         kind;

  assign flush   = (kind == RET_FLUSH);
  assign pop_n   = (kind == RET_TWO) ? 2'd2 : (kind == RET_ONE) ? 2'd1 : 2'd0;
  assign push    = alloc_valid && alloc_ready;
  assign cmp_idx = cmp_tag[IDX_W-1:0];
  assign cmp_hit = cmp_valid && (cmp_tag[IDX_W] == epoch) && v_q[cmp_idx] && !flush;

  retire_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .pop_n   (pop_n),
    .flush   (flush),
    .head_q  (head),
    .tail_q  (tail),
    .cnt_q   (cnt),
    .epoch_q (epoch),
    .full    (full)
  );

  retire_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (push),
    .alloc_idx  (tail),
    .alloc_dest (alloc_dest),
    .cmp_en     (cmp_hit),
    .cmp_idx    (cmp_idx),
    .cmp_data   (cmp_data),
    .cmp_exc    (cmp_exc),
    .clr_mask   (rel_mask),
    .valid_o    (v_q),
    .done_o     (d_q),
    .exc_o      (e_q),
    .dest_o     (dest_q),
    .data_o     (data_q)
  );

  retire_select #(.DEPTH(DEPTH)) u_sel (
    .head     (head),
    .valid    (v_q),
    .done     (d_q),
    .exc      (e_q),
    .kind     (kind),
    .idx0     (idx0),
    .idx1     (idx1),
    .rel_mask (rel_mask)
  );

  assign alloc_ready = !full && !flush;
  assign alloc_tag   = {epoch, tail};
  assign wr0_en      = (kind == RET_ONE) || (kind == RET_TWO);
  assign wr0_addr    = dest_q[idx0];
  assign wr0_data    = data_q[idx0];
  assign wr1_en      = (kind == RET_TWO);
  assign wr1_addr    = dest_q[idx1];
  assign wr1_data    = data_q[idx1];
  assign exc_valid   = flush;
  assign exc_tag     = {epoch, idx0};
  assign free_mask   = rel_mask;

  a_r5_pair_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> wr0_en)
    else $error("second port committed without the first");

  a_r6_flush_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !wr0_en && !wr1_en)
    else $error("commit during exception report");

  a_r4_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en && !wr1_en) |=> head == $past(idx1))
    else $error("single commit did not advance the oldest pointer by one");

  a_r3_commit_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr0_en |-> v_q[head] && d_q[head])
    else $error("commit of an unfinished slot");

  a_r8_free_count: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> $countones(free_mask) == 32'(wr0_en) + 32'(wr1_en))
    else $error("release mask does not match commits");

endmodule

// File: tb/retire_order_unit_tb.sv
module retire_order_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid, alloc_ready, cmp_valid, cmp_exc;
  logic [4:0]  alloc_dest, wr0_addr, wr1_addr;
  logic [3:0]  alloc_tag, cmp_tag, exc_tag;
  logic [31:0] cmp_data, wr0_data, wr1_data;
  logic        wr0_en, wr1_en, exc_valid;
  logic [7:0]  free_mask;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  retire_order_unit #(.DEPTH(8), .DATA_W(32), .AREG_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
    .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
    .exc_valid(exc_valid), .exc_tag(exc_tag), .free_mask(free_mask)
  );

  // Reference model: outstanding instructions kept in program order.
  logic [3:0]  m_tag  [8];
  logic [4:0]  m_dest [8];
  logic [31:0] m_data [8];
  bit          m_done [8];
  bit          m_exc  [8];
  int          m_cnt   = 0;
  int          m_next  = 0;
  bit          m_epoch = 1'b0;
  logic [3:0]  last_tag;
  bit          last_ok;
  logic [31:0] rng = 32'h1234_5677;

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit av, input logic [4:0] ad, input bit cv,
                      input logic [3:0] ct, input logic [31:0] cd, input bit ce);
    bit k0, k1, fl, rdy;
    logic [7:0] fm;
    int n;
    k0 = (m_cnt > 0) && m_done[0] && !m_exc[0];
    fl = (m_cnt > 0) && m_done[0] &&  m_exc[0];
    k1 = k0 && (m_cnt > 1) && m_done[1] && !m_exc[1];
    fm = '0;
    if (fl) begin
      for (int i = 0; i < m_cnt; i++) fm[m_tag[i][2:0]] = 1'b1;
    end else begin
      if (k0) fm[m_tag[0][2:0]] = 1'b1;
      if (k1) fm[m_tag[1][2:0]] = 1'b1;
    end
    rdy = (m_cnt < 8) && !fl;
    chk(wr0_en == k0, "R4", 32'(wr0_en), 32'(k0));
    if (k0) begin
      chk(wr0_addr == m_dest[0], "R4", 32'(wr0_addr), 32'(m_dest[0]));
      chk(wr0_data == m_data[0], "R3", wr0_data, m_data[0]);
    end
    chk(wr1_en == k1, "R5", 32'(wr1_en), 32'(k1));
    if (k1) begin
      chk(wr1_addr == m_dest[1], "R5", 32'(wr1_addr), 32'(m_dest[1]));
      chk(wr1_data == m_data[1], "R5", wr1_data, m_data[1]);
    end
    chk(exc_valid == fl, "R6 R9", 32'(exc_valid), 32'(fl));
    if (fl) chk(exc_tag == m_tag[0], "R6", 32'(exc_tag), 32'(m_tag[0]));
    chk(free_mask == fm, "R8", 32'(free_mask), 32'(fm));
    chk(alloc_ready == rdy, "R2", 32'(alloc_ready), 32'(rdy));
    chk(alloc_tag == {m_epoch, 3'(m_next)}, "R2", 32'(alloc_tag), 32'({m_epoch, 3'(m_next)}));
    alloc_valid = av; alloc_dest = ad;
    cmp_valid = cv; cmp_tag = ct; cmp_data = cd; cmp_exc = ce;
    last_ok  = av && rdy;
    last_tag = {m_epoch, 3'(m_next)};
    @(posedge clk);
    if (fl) begin
      m_cnt = 0; m_epoch = ~m_epoch; m_next = 0;
    end else begin
      if (cv) begin
        for (int i = 0; i < m_cnt; i++)
          if (m_tag[i] == ct) begin
            m_done[i] = 1'b1; m_data[i] = cd; m_exc[i] = ce;
          end
      end
      n = int'(k0) + int'(k1);
      for (int i = 0; i + n < m_cnt; i++) begin
        m_tag[i] = m_tag[i+n]; m_dest[i] = m_dest[i+n]; m_data[i] = m_data[i+n];
        m_done[i] = m_done[i+n]; m_exc[i] = m_exc[i+n];
      end
      m_cnt = m_cnt - n;
      if (last_ok) begin
        m_tag[m_cnt] = last_tag; m_dest[m_cnt] = ad; m_data[m_cnt] = '0;
        m_done[m_cnt] = 1'b0; m_exc[m_cnt] = 1'b0;
        m_cnt++;
        m_next = (m_next + 1) % 8;
      end
    end
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, '0, '0, 1'b0);
  endtask

  task automatic drain();
    for (int i = 0; i < 12 && m_cnt > 0; i++) idle();
    idle();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  function automatic int perm(input int p, input int i);
    case (p)
      0: return i;
      1: return 7 - i;
      2: return (3 * i) % 8;
      3: return (5 * i + 2) % 8;
      4: return i ^ 1;
      default: return (i + 4) % 8;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] lt [8];
    logic [3:0] n0, n1;
    rst_n = 1'b0;
    alloc_valid = 0; alloc_dest = '0; cmp_valid = 0; cmp_tag = '0; cmp_data = '0; cmp_exc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(alloc_ready == 1'b1, "R1", 32'(alloc_ready), 32'd1);
    chk(alloc_tag == 4'd0, "R1", 32'(alloc_tag), 32'd0);
    chk(!wr0_en && !wr1_en, "R1", 32'({wr0_en, wr1_en}), 32'd0);
    chk(exc_valid == 1'b0, "R1", 32'(exc_valid), 32'd0);
    chk(free_mask == 8'd0, "R1", 32'(free_mask), 32'd0);

    // R4 R5: completion order sweep over a full buffer, plus refused allocation (R2)
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 8; i++) begin
        step(1'b1, 5'((3 * i + p) % 32), 1'b0, '0, '0, 1'b0);
        lt[i] = last_tag;
      end
      step(1'b1, 5'd31, 1'b0, '0, '0, 1'b0);
      chk(last_ok == 1'b0, "R2", 32'(last_ok), 32'd0);
      for (int i = 0; i < 8; i++)
        step(1'b0, '0, 1'b1, lt[perm(p, i)], 32'h100 * p + 32'(perm(p, i)) + 32'h5a00, 1'b0);
      drain();
    end

    // R6 R9: exception at every position, completed youngest first
    for (int pos = 0; pos < 8; pos++) begin
      for (int i = 0; i < 8; i++) begin
        step(1'b1, 5'(i + pos), 1'b0, '0, '0, 1'b0);
        lt[i] = last_tag;
      end
      for (int j = 7; j >= 0; j--)
        step(1'b0, '0, 1'b1, lt[j], 32'hE000 + 32'(j), (j == pos));
      drain();
      chk(alloc_tag == {m_epoch, 3'd0}, "R6", 32'(alloc_tag), 32'({m_epoch, 3'd0}));
      // R7: stale completion into an empty buffer, then into a reused slot
      step(1'b0, '0, 1'b1, lt[0], 32'hDEAD, 1'b0);
      step(1'b1, 5'd7, 1'b0, '0, '0, 1'b0);
      n0 = last_tag;
      step(1'b1, 5'd9, 1'b0, '0, '0, 1'b0);
      n1 = last_tag;
      step(1'b0, '0, 1'b1, lt[0], 32'hBAD0, 1'b0);
      chk(wr0_en == 1'b0, "R7", 32'(wr0_en), 32'd0);
      step(1'b0, '0, 1'b1, n1, 32'h1111, 1'b0);
      step(1'b0, '0, 1'b1, n0, 32'h2222, 1'b0);
      chk(wr0_en && wr1_en && wr0_data == 32'h2222, "R5", wr0_data, 32'h2222);
      drain();
    end

    // Mixed pseudo-random traffic
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      bit av, cv, ce;
      logic [3:0] ct;
      int k;
      r  = rnd();
      av = (r[3:0] < 4'd10);
      cv = 1'b0; ce = 1'b0; ct = '0;
      if (r[7:4] == 4'd0) begin
        cv = 1'b1; ct = {~m_epoch, r[10:8]};
      end else if (m_cnt > 0 && r[6:4] != 3'd1) begin
        k = int'(r[15:12]) % m_cnt;
        for (int t = 0; t < 8 && m_done[k]; t++) k = (k + 1) % m_cnt;
        if (!m_done[k]) begin
          cv = 1'b1; ct = m_tag[k]; ce = (r[20:17] == 4'd0);
        end
      end
      step(av, r[25:21], cv, ct, rnd(), ce);
    end
    drain();

    summary();
    $finish;
  end

endmodule